// File: doc/BRIEF.md
# Double-Buffered Serial Line Transmitter

This block drives one asynchronous NRZ serial line. A write port places a word into a one-word holding register. A separate shift register serialises one frame at a time. A frame is a low start bit, then 8 or 9 data bits with the least significant bit first, then a high stop bit. The holding register hands its word to the shift register only after the current frame's stop bit has ended. If a word is waiting at that point, the next start bit follows the stop bit with no gap. A built-in divider sets the bit period from a programmable divisor, in narrow (8-bit) or wide (16-bit) mode, with 16 or 64 divider ticks per bit.

Software watches two indicators. The holding-empty interrupt flag has no clear operation of its own; only a write clears it, and it shows the cleared value one cycle late. The shift-empty status bit is high whenever no frame is on the line. A write to a full holding register is dropped and sets a sticky error flag. Dropping the enable aborts any frame and discards both registers.

The shifter is a state machine with five states. OFF is held while disabled; OFF goes to IDLE once enabled. IDLE goes to START when the holding register is full, which loads the shifter. START goes to DATA after one bit period. DATA goes to STOP after the last data bit. STOP goes to START when a word is waiting, loading it in the same cycle, and otherwise goes to IDLE. Any state goes to OFF when the enable is low.

Top module: `sertx_core`

## Requirements
- R1: The frame on `txd` is: start bit at 0, data bits least significant first, stop bit at 1. `txd` is 1 whenever no frame is being sent, including while disabled.
- R2: With `nine_bit`=1, `wr_bit8` (captured at the write) goes out as a ninth data bit after bit 7. With `nine_bit`=0, exactly 8 data bits are sent. No parity is generated.
- R3: Every bit, the start bit included, lasts TPB*(D+1) clock cycles. TPB is 16 when `slow_bits`=0 and 64 when `slow_bits`=1. D is `div_val[7:0]` when `wide_div`=0 and `div_val[15:0]` when `wide_div`=1.
- R4: The shift register loads only from IDLE or at the end of a stop bit. With a word waiting, consecutive start bits are exactly (N+2) bit periods apart, where N is the number of data bits.
- R5: While enabled, `hold_empty_irq` is 1 when the holding register is empty. It returns to 1 one cycle after a word moves into the shift register.
- R6: An accepted write clears `hold_empty_irq`, but only from the second rising edge after the write edge. Between those edges the old value 1 is still seen.
- R7: `shift_empty` is 0 from the load cycle through the stop bit, and 1 otherwise. It stays 0 across a back-to-back frame boundary.
- R8: When `tx_en` rises with nothing written, `hold_empty_irq` is 1 after the first rising edge.
- R9: A write while the holding register is full is dropped and sets `ovr_err`. `ovr_err` stays set until `tx_en` goes low.
- R10: At the first rising edge with `tx_en`=0, `txd` becomes 1, `shift_empty` 1, and `hold_empty_irq` and `ovr_err` 0. A frame in progress and a waiting word are discarded, and no frame follows re-enabling.
- R11: A write while `tx_en`=0 is ignored, and no frame results once the block is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable; low aborts and empties |
| nine_bit | input | 1 | 1 selects 9 data bits per frame |
| wide_div | input | 1 | 1 uses all 16 divisor bits, 0 only the low 8 |
| slow_bits | input | 1 | 1 gives 64 divider ticks per bit, 0 gives 16 |
| div_val | input | 16 | Divisor D; divider tick every D+1 cycles |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Data word to send |
| wr_bit8 | input | 1 | Ninth data bit, captured with the word |
| txd | output | 1 | Serial line output |
| hold_empty_irq | output | 1 | Holding-register-empty interrupt flag |
| shift_empty | output | 1 | Shift register idle status |
| ovr_err | output | 1 | Sticky dropped-write flag |

## Verification
The bench aims at the frame boundary. A design that reloaded the shifter early, or added an idle bit, would break the exact spacing of start bits and the unbroken low level of `shift_empty`. It samples the flag in the single cycle between a write and its delayed clear, where a design without the lag would already read 0. A third write into a full holding register would corrupt the pending word, or add a third frame, if it were not dropped. The bench aborts mid-frame with a word waiting; a design that kept the word would send a stray frame on re-enable. Frames in the 64x and wide-divisor modes are decoded at mid-bit, so a wrong tick count or a truncated divisor garbles the word.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_IDLE  = 3'd1,
        ST_START = 3'd2,
        ST_DATA  = 3'd3,
        ST_STOP  = 3'd4
    } tx_state_e;

    localparam int OVS_FAST_DEF = 16;
    localparam int OVS_SLOW_DEF = 64;

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
    parameter int DIV_W    = 16,
    parameter int NARROW_W = 8,
    parameter int OVS_FAST = sertx_pkg::OVS_FAST_DEF,
    parameter int OVS_SLOW = sertx_pkg::OVS_SLOW_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             wide_div,
    input  logic             slow_bits,
    input  logic [DIV_W-1:0] div_val,
    output logic             bit_done
);
    localparam int TC_W = $clog2(OVS_SLOW);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;
    logic [TC_W-1:0]  tcnt;
    logic [TC_W-1:0]  tlast;
    logic             tick;

    generate
        if (NARROW_W < DIV_W) begin : g_pad
            assign limit = wide_div ? div_val : DIV_W'(div_val[NARROW_W-1:0]);
        end else begin : g_full
            assign limit = div_val;
        end
    endgenerate

    assign tlast    = slow_bits ? TC_W'(OVS_SLOW - 1) : TC_W'(OVS_FAST - 1);
    assign tick     = (cnt == limit);
    assign bit_done = tick && (tcnt == tlast);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tcnt <= '0;
        end else if (restart) begin
            cnt  <= '0;
            tcnt <= '0;
        end else if (tick) begin
            cnt  <= '0;
            tcnt <= (tcnt == tlast) ? '0 : tcnt + 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              take,
    output logic              full,
    output logic [WORD_W-1:0] word,
    output logic              irq,
    output logic              ovr_err
);
    logic accept;
    logic reject;

    assign accept = tx_en && wr_en && !full;
    assign reject = tx_en && wr_en && full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full    <= 1'b0;
            word    <= '0;
            irq     <= 1'b0;
            ovr_err <= 1'b0;
        end else if (!tx_en) begin
            full    <= 1'b0;
            irq     <= 1'b0;
            ovr_err <= 1'b0;
        end else begin
            irq <= !full;
            if (accept) begin
                full <= 1'b1;
                word <= wr_word;
            end else if (take) begin
                full <= 1'b0;
            end
            if (reject) begin
                ovr_err <= 1'b1;
            end
        end
    end

    AST_REJECT_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && wr_en && full) |=> ovr_err); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_err && tx_en) |=> ovr_err); // R9
    AST_FLAG_CLEARS_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && wr_en && !full) ##1 tx_en |=> !irq); // R6

endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm #(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              full,
    input  logic [WORD_W-1:0] hold_word,
    input  logic              nine_bit,
    input  logic              bit_done,
    output logic              take,
    output logic              restart,
    output logic              txd,
    output logic              shift_empty
);
    import sertx_pkg::*;

    localparam int IDX_W = $clog2(WORD_W);

    tx_state_e         state;
    tx_state_e         nxt;
    logic [WORD_W-1:0] shreg;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  last_idx;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:   nxt = ST_IDLE;
            ST_IDLE:  if (full) nxt = ST_START;
            ST_START: if (bit_done) nxt = ST_DATA;
            ST_DATA:  if (bit_done && idx == last_idx) nxt = ST_STOP;
            ST_STOP:  if (bit_done) nxt = full ? ST_START : ST_IDLE;
            default:  nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else if (!tx_en) begin
            state <= ST_OFF;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        take        = 1'b0;
        restart     = 1'b0;
        txd         = 1'b1;
        shift_empty = 1'b0;
        unique case (state)
            ST_OFF: begin
                restart     = 1'b1;
                shift_empty = 1'b1;
            end
            ST_IDLE: begin
                take        = tx_en && full;
                restart     = 1'b1;
                shift_empty = 1'b1;
            end
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg[0];
            ST_STOP: begin
                take    = tx_en && full && bit_done;
                restart = take;
            end
            default: shift_empty = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            idx      <= '0;
            last_idx <= '0;
        end else if (take) begin
            shreg    <= hold_word;
            idx      <= '0;
            last_idx <= nine_bit ? IDX_W'(WORD_W - 1) : IDX_W'(WORD_W - 2);
        end else if (state == ST_DATA && bit_done) begin
            shreg    <= shreg >> 1;
            idx      <= idx + 1'b1;
        end
    end

    AST_LOAD_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && $past(state) != ST_START) |->
        ($past(state) == ST_IDLE || $past(state) == ST_STOP)); // R4

endmodule

// File: rtl/sertx_core.sv
module sertx_core #(
    parameter int DIV_W    = 16,
    parameter int NARROW_W = 8,
    parameter int DATA_W   = 8,
    parameter int OVS_FAST = sertx_pkg::OVS_FAST_DEF,
    parameter int OVS_SLOW = sertx_pkg::OVS_SLOW_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              nine_bit,
    input  logic              wide_div,
    input  logic              slow_bits,
    input  logic [DIV_W-1:0]  div_val,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bit8,
    output logic              txd,
    output logic              hold_empty_irq,
    output logic              shift_empty,
    output logic              ovr_err
);
    localparam int WORD_W = DATA_W + 1;

    logic              full;
    logic [WORD_W-1:0] hold_word;
    logic              take;
    logic              restart;
    logic              bit_done;

    sertx_baud #(
        .DIV_W    (DIV_W),
        .NARROW_W (NARROW_W),
        .OVS_FAST (OVS_FAST),
        .OVS_SLOW (OVS_SLOW)
    ) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .wide_div  (wide_div),
        .slow_bits (slow_bits),
        .div_val   (div_val),
        .bit_done  (bit_done)
    );

    sertx_hold #(
        .WORD_W (WORD_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en   (tx_en),
        .wr_en   (wr_en),
        .wr_word ({wr_bit8, wr_data}),
        .take    (take),
        .full    (full),
        .word    (hold_word),
        .irq     (hold_empty_irq),
        .ovr_err (ovr_err)
    );

    sertx_fsm #(
        .WORD_W (WORD_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .full        (full),
        .hold_word   (hold_word),
        .nine_bit    (nine_bit),
        .bit_done    (bit_done),
        .take        (take),
        .restart     (restart),
        .txd         (txd),
        .shift_empty (shift_empty)
    );

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> txd); // R1
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (txd && shift_empty && !hold_empty_irq && !ovr_err)); // R10

endmodule

// File: tb/sertx_core_bench.sv
module sertx_core_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [8:0] word;
        logic       nine;
        logic       b2b;
    } frame_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0;
    logic        nine_bit = 1'b0;
    logic        wide_div = 1'b0;
    logic        slow_bits = 1'b0;
    logic [15:0] div_val = 16'd2;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        wr_bit8 = 1'b0;
    logic        txd;
    logic        hold_empty_irq;
    logic        shift_empty;
    logic        ovr_err;

    frame_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int bp = 48;
    int cyc = 0;
    bit ignore_frames = 1'b0;

    sertx_core u_sertx_core (
        .clk            (clk),
        .rst_n          (rst_n),
        .tx_en          (tx_en),
        .nine_bit       (nine_bit),
        .wide_div       (wide_div),
        .slow_bits      (slow_bits),
        .div_val        (div_val),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .wr_bit8        (wr_bit8),
        .txd            (txd),
        .hold_empty_irq (hold_empty_irq),
        .shift_empty    (shift_empty),
        .ovr_err        (ovr_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Driver: one write strobe; an accepted word is pushed as an expected frame.
    task automatic put(input logic [7:0] d, input logic b8,
                       input bit accepted, input bit b2b);
        frame_t it;
        @(negedge clk);
        wr_data = d;
        wr_bit8 = b8;
        wr_en   = 1'b1;
        if (accepted) begin
            it.word = {b8, d};
            it.nine = nine_bit;
            it.b2b  = b2b;
            exp_q.push_back(it);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (4) @(negedge clk);
        while (!(shift_empty && hold_empty_irq)) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R4", "all queued frames sent", exp_q.size(), 0);
    endtask

    // Monitor: decodes frames at mid-bit and compares with the scoreboard.
    initial begin
        logic prev;
        int   last_fall;
        int   last_len;
        prev      = 1'b1;
        last_fall = 0;
        last_len  = 0;
        forever begin
            @(negedge clk);
            if (prev && !txd && tx_en && !ignore_frames) begin
                frame_t     it;
                int         nb;
                logic [8:0] got;
                logic [8:0] want;
                bit         lvl_ok;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected frame start", 1, 0);
                end else begin
                    it = exp_q.pop_front();
                    nb = it.nine ? 9 : 8;
                    if (it.b2b)
                        chk(cyc - last_fall == last_len * bp, "R4", "start spacing",
                            cyc - last_fall, last_len * bp);
                    last_fall = cyc;
                    last_len  = nb + 2;
                    repeat (bp/2) @(negedge clk);
                    lvl_ok = (txd == 1'b0);
                    got = '0;
                    for (int i = 0; i < nb; i++) begin
                        repeat (bp) @(negedge clk);
                        got[i] = txd;
                    end
                    repeat (bp) @(negedge clk);
                    lvl_ok = lvl_ok && (txd == 1'b1);
                    want = it.nine ? it.word : {1'b0, it.word[7:0]};
                    chk(lvl_ok, "R1", "start/stop levels", int'(lvl_ok), 1);
                    chk(got == want, "R2/R3", "decoded frame word", int'(got), int'(want));
                end
            end
            prev = txd;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int lows;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1 && shift_empty && !hold_empty_irq && !ovr_err, "R1",
            "reset state", {txd, shift_empty, hold_empty_irq, ovr_err}, 4'b1100);

        // R11: write while disabled is ignored
        put(8'h3E, 1'b0, 1'b0, 1'b0);
        tx_en = 1'b1;
        @(negedge clk);
        chk(hold_empty_irq == 1'b1, "R8", "flag set by enable", hold_empty_irq, 1);
        lows = 0;
        repeat (4 * bp) begin
            @(negedge clk);
            if (!shift_empty) lows++;
        end
        chk(lows == 0, "R11", "no frame from disabled write", lows, 0);

        // R1 single 8-bit frame
        put(8'hA5, 1'b1, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        chk(shift_empty == 1'b0, "R7", "busy during frame", shift_empty, 0);
        wait_idle();

        // R6 / R4 / R5: back-to-back with delayed flag clear
        put(8'h3C, 1'b0, 1'b1, 1'b0);
        repeat (5) @(negedge clk);
        wr_data = 8'hC3;
        wr_bit8 = 1'b0;
        wr_en   = 1'b1;
        begin
            frame_t it;
            it.word = 9'h0C3;
            it.nine = 1'b0;
            it.b2b  = 1'b1;
            exp_q.push_back(it);
        end
        @(negedge clk);
        wr_en = 1'b0;
        chk(hold_empty_irq == 1'b1, "R6", "stale flag one cycle after write", hold_empty_irq, 1);
        @(negedge clk);
        chk(hold_empty_irq == 1'b0, "R6", "flag cleared second cycle", hold_empty_irq, 0);
        lows = 0;
        while (exp_q.size() != 0) begin
            @(negedge clk);
            if (shift_empty) lows++;
        end
        chk(lows == 0, "R7", "shift_empty low across boundary", lows, 0);
        @(negedge clk);
        chk(hold_empty_irq == 1'b1, "R5", "flag set after transfer", hold_empty_irq, 1);
        wait_idle();

        // R2: nine-bit frames
        nine_bit = 1'b1;
        put(8'h5A, 1'b1, 1'b1, 1'b0);
        repeat (4) @(negedge clk);
        put(8'h0F, 1'b0, 1'b1, 1'b1);
        wait_idle();
        nine_bit = 1'b0;

        // R9: third write into full holding register is dropped
        put(8'h11, 1'b0, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        put(8'h22, 1'b0, 1'b1, 1'b1);
        put(8'h99, 1'b0, 1'b0, 1'b0);
        chk(ovr_err == 1'b1, "R9", "error on dropped write", ovr_err, 1);
        wait_idle();
        chk(ovr_err == 1'b1, "R9", "error sticky", ovr_err, 1);

        // R10: abort mid-frame with a waiting word
        ignore_frames = 1'b1;
        put(8'h00, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        put(8'h77, 1'b0, 1'b0, 1'b0);
        repeat (100) @(negedge clk);
        chk(shift_empty == 1'b0, "R7", "busy before abort", shift_empty, 0);
        tx_en = 1'b0;
        @(negedge clk);
        chk(txd && shift_empty && !hold_empty_irq && !ovr_err, "R10",
            "abort state", {txd, shift_empty, hold_empty_irq, ovr_err}, 4'b1100);
        tx_en = 1'b1;
        ignore_frames = 1'b0;
        lows = 0;
        repeat (15 * bp) begin
            @(negedge clk);
            if (!shift_empty) lows++;
        end
        chk(lows == 0, "R10", "waiting word discarded", lows, 0);

        // R3: 64 ticks per bit, divisor 0
        slow_bits = 1'b1;
        div_val   = 16'd0;
        bp        = 64;
        put(8'h81, 1'b0, 1'b1, 1'b0);
        wait_idle();

        // R3: wide divisor 0x0100 (narrow view would be 0)
        slow_bits = 1'b0;
        wide_div  = 1'b1;
        div_val   = 16'h0100;
        bp        = 257 * 16;
        put(8'h6B, 1'b0, 1'b1, 1'b0);
        wait_idle();

        finish_run();
    end

endmodule